// File: doc/BRIEF.md
# NAND Flash Register Controller with Running Page ECC

This block is a small byte-wide register window that a host uses to drive a raw NAND flash device by software. A control register sets the command-latch, address-latch, write-protect and two chip-enable bits, and those bits go straight to the NAND pins. A data register passes bytes to the device on a host write and from the device on a host read. The host reads the device's ready/busy level through a read-only bit of the control register.

Each byte that crosses the data register in either direction also feeds a page ECC accumulator. The accumulator keeps six column parity bits, two 8-bit line parity words that depend on each byte's index within a 256-byte page, and a byte counter. The host reads these through dedicated registers and clears them with a single write. The line parity is read back with the two words interleaved bit by bit across two registers. Error correction itself is left to software.

Top module: `nand_ecc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control register is 0, all NAND pin outputs are low, and the counter, column parity and both line parity registers read 0.
- R2: A write to offset 0x18 stores all 8 data bits except bit 5, which is stored as 0. A read of 0x18 returns the stored value with bit 5 replaced by the live level of `nand_rdy`.
- R3: `nand_cle` follows control bit 1, `nand_ale` bit 2 and `nand_wp` bit 3. `nand_ce` is high when control bit 0 or bit 4 is set.
- R4: During a host write to offset 0x14, `nand_wr_stb` is high and `nand_dout` equals the written byte in that same cycle. At all other times `nand_wr_stb` is low.
- R5: During a host read of offset 0x14, `nand_rd_stb` is high and `bus_rdata` equals `nand_din` in that same cycle. At all other times `nand_rd_stb` is low.
- R6: Every data-register access increments the byte counter by one, effective the next cycle. A read of offset 0x0C returns the count modulo 256, so 256 bytes read as 0.
- R7: Column parity (read at 0x08, bits 5..0, bits 7..6 zero) is the XOR over all accumulated bytes of these six values: bit0 = XOR of byte bits {0,2,4,6}, bit1 = {1,3,5,7}, bit2 = {0,1,4,5}, bit3 = {2,3,6,7}, bit4 = {0,1,2,3}, bit5 = {4,5,6,7}.
- R8: Each accumulated byte has an index equal to the byte count before it, modulo 256. A byte with an odd number of set bits XORs the inverted index into line word A and the plain index into line word B. A byte with even parity leaves both words unchanged.
- R9: Offset 0x00 returns A[4+k] at bit 2k and B[4+k] at bit 2k+1, for k = 0..3. Offset 0x04 returns A[k] at bit 2k and B[k] at bit 2k+1.
- R10: Any write to offset 0x10, whatever its data, zeroes the counter, the column parity and both line words. The control register is not changed.
- R11: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x14 and 0x18 (including 0x10) return 0. Writes to any offset other than 0x10, 0x14 and 0x18 change no state. The ECC state changes only on data accesses and clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte offset within the register window |
| bus_wdata | input | DATA_W (8) | Host write data |
| bus_rdata | output | DATA_W (8) | Host read data, combinational |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce | output | 1 | Chip enable, active high |
| nand_wp | output | 1 | Write protect |
| nand_dout | output | DATA_W (8) | Byte to the device |
| nand_wr_stb | output | 1 | Write strobe for `nand_dout` |
| nand_din | input | DATA_W (8) | Byte from the device |
| nand_rd_stb | output | 1 | Read strobe, device advances after it |
| nand_rdy | input | 1 | Device ready (1) / busy (0) |

## Verification
The assertions assume that the host issues at most one access per cycle. They also assume that `bus_addr`, `bus_wr` and `bus_wdata` are known whenever `bus_sel` is high, and that `nand_din` is known during a data read. The bench meets these assumptions as follows: it drives every input on the falling clock edge and returns `bus_sel` low between accesses. It drives reset low before the first rising edge. It serves reads from a preloaded page through a responder that advances only on `nand_rd_stb`.

// File: rtl/nandc_pkg.sv
// Shared constants and types of the NAND register controller.
// Assumes a byte-addressed window with word-aligned register offsets.
package nandc_pkg;
    // Register byte offsets (decoded by host software, so fixed)
    localparam int unsigned OFF_LP_LO  = 32'h00;
    localparam int unsigned OFF_LP_HI  = 32'h04;
    localparam int unsigned OFF_COLPAR = 32'h08;
    localparam int unsigned OFF_COUNT  = 32'h0C;
    localparam int unsigned OFF_CLEAR  = 32'h10;
    localparam int unsigned OFF_DATA   = 32'h14;
    localparam int unsigned OFF_CTRL   = 32'h18;

    // Control register bit positions
    localparam int unsigned CB_CE0  = 0;
    localparam int unsigned CB_CLE  = 1;
    localparam int unsigned CB_ALE  = 2;
    localparam int unsigned CB_WP   = 3;
    localparam int unsigned CB_CE1  = 4;
    localparam int unsigned CB_BUSY = 5;

    // One flag per decoded register
    typedef struct packed {
        logic lp_lo;
        logic lp_hi;
        logic colpar;
        logic count;
        logic clear;
        logic data;
        logic ctrl;
    } reg_hit_t;
endpackage

// File: rtl/nandc_dec.sv
// Address decoder: turns a byte offset into one flag per register.
// Assumes ADDR_W is wide enough to hold the highest offset (0x18).
module nandc_dec
    import nandc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);
    // Full-width compare of the offset against each register
    always_comb begin
        hit.lp_lo  = (addr == ADDR_W'(OFF_LP_LO));
        hit.lp_hi  = (addr == ADDR_W'(OFF_LP_HI));
        hit.colpar = (addr == ADDR_W'(OFF_COLPAR));
        hit.count  = (addr == ADDR_W'(OFF_COUNT));
        hit.clear  = (addr == ADDR_W'(OFF_CLEAR));
        hit.data   = (addr == ADDR_W'(OFF_DATA));
        hit.ctrl   = (addr == ADDR_W'(OFF_CTRL));
    end
endmodule

// File: rtl/nandc_ecc_acc.sv
// Running page ECC accumulator: byte counter, column parity and two
// line parity words. Page length is 2**DATA_W bytes. Each strobed
// byte is folded in at the next clock edge.
// Assumes clr and stb are never both high (one host access per cycle).
module nandc_ecc_acc #(
    parameter int DATA_W  = 8,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               stb,
    input  logic [DATA_W-1:0]  din,
    output logic [COUNT_W-1:0] cnt,
    output logic [2*$clog2(DATA_W)-1:0] cp,
    output logic [DATA_W-1:0]  lp_a,
    output logic [DATA_W-1:0]  lp_b
);
    localparam int BIT_IDX_W = $clog2(DATA_W);
    localparam int CP_W      = 2 * BIT_IDX_W;

    // Mask of the bit columns whose index bit k equals sel
    function automatic logic [DATA_W-1:0] col_mask(input int k, input logic sel);
        logic [DATA_W-1:0] m;
        for (int j = 0; j < DATA_W; j++) begin
            m[j] = (((j >> k) & 1) == int'(sel));
        end
        return m;
    endfunction

    logic [CP_W-1:0]   cp_byte;
    logic              byte_par;
    logic [DATA_W-1:0] idx;

    // Column parity of the incoming byte, one pair per index bit
    for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_col
        assign cp_byte[2*k]   = ^(din & col_mask(k, 1'b0));
        assign cp_byte[2*k+1] = ^(din & col_mask(k, 1'b1));
    end

    assign byte_par = ^din;
    assign idx      = cnt[DATA_W-1:0];

    // Accumulate on a strobe; clear and reset zero everything
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            cp   <= '0;
            lp_a <= '0;
            lp_b <= '0;
        end else if (stb) begin
            cnt <= cnt + COUNT_W'(1);
            cp  <= cp ^ cp_byte;
            if (byte_par) begin
                lp_a <= lp_a ^ ~idx;
                lp_b <= lp_b ^ idx;
            end
        end
    end
endmodule

// File: rtl/nandc_lp_pack.sv
// Line parity readback packer: interleaves the two line words bit by
// bit. The upper halves go to the low register and the lower halves
// to the high register.
// Assumes DATA_W is even.
module nandc_lp_pack #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] lp_a,
    input  logic [DATA_W-1:0] lp_b,
    output logic [DATA_W-1:0] rd_lo,
    output logic [DATA_W-1:0] rd_hi
);
    localparam int HALF_W = DATA_W / 2;

    // Word A on even positions, word B on odd positions
    for (genvar k = 0; k < HALF_W; k++) begin : g_pair
        assign rd_lo[2*k]   = lp_a[HALF_W + k];
        assign rd_lo[2*k+1] = lp_b[HALF_W + k];
        assign rd_hi[2*k]   = lp_a[k];
        assign rd_hi[2*k+1] = lp_b[k];
    end
endmodule

// File: rtl/nand_ecc_ctrl.sv
// NAND register controller top. It decodes host accesses, holds the
// pin control register, passes data bytes to and from the device with
// single-cycle strobes, and feeds every data byte to the ECC
// accumulator. Read data is combinational from the current access.
// Assumes one host access per cycle. The device must sample nand_dout
// on nand_wr_stb and advance its output after nand_rd_stb.
module nand_ecc_ctrl
    import nandc_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int COUNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_ce,
    output logic              nand_wp,
    output logic [DATA_W-1:0] nand_dout,
    output logic              nand_wr_stb,
    input  logic [DATA_W-1:0] nand_din,
    output logic              nand_rd_stb,
    input  logic              nand_rdy
);
    localparam int CP_W = 2 * $clog2(DATA_W);
    localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << CB_BUSY;

    reg_hit_t            hit;
    logic                acc_wr, acc_rd;
    logic                io_wr, io_rd, clr_wr, ctl_wr;
    logic [DATA_W-1:0]   ctl_q;
    logic [DATA_W-1:0]   acc_byte;
    logic [COUNT_W-1:0]  ecc_cnt;
    logic [CP_W-1:0]     ecc_cp;
    logic [DATA_W-1:0]   ecc_lp0, ecc_lp1;
    logic [DATA_W-1:0]   lp_rd_lo, lp_rd_hi;

    nandc_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    // Access qualifiers
    assign acc_wr = bus_sel &  bus_wr;
    assign acc_rd = bus_sel & ~bus_wr;
    assign io_wr  = acc_wr & hit.data;
    assign io_rd  = acc_rd & hit.data;
    assign clr_wr = acc_wr & hit.clear;
    assign ctl_wr = acc_wr & hit.ctrl;

    // Control register; the busy position is never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= bus_wdata & ~BUSY_MASK;
        end
    end

    // Pin drive from the control register
    assign nand_cle = ctl_q[CB_CLE];
    assign nand_ale = ctl_q[CB_ALE];
    assign nand_wp  = ctl_q[CB_WP];
    assign nand_ce  = ctl_q[CB_CE0] | ctl_q[CB_CE1];

    // Data path and strobes to the device
    assign nand_dout   = bus_wdata;
    assign nand_wr_stb = io_wr;
    assign nand_rd_stb = io_rd;

    // Byte presented to the ECC: host data on write, device data on read
    assign acc_byte = io_wr ? bus_wdata : nand_din;

    nandc_ecc_acc #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_ecc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_wr),
        .stb   (io_wr | io_rd),
        .din   (acc_byte),
        .cnt   (ecc_cnt),
        .cp    (ecc_cp),
        .lp_a  (ecc_lp0),
        .lp_b  (ecc_lp1)
    );

    nandc_lp_pack #(.DATA_W(DATA_W)) u_pack (
        .lp_a  (ecc_lp0),
        .lp_b  (ecc_lp1),
        .rd_lo (lp_rd_lo),
        .rd_hi (lp_rd_hi)
    );

    // Read mux; anything undecoded or write-only reads as zero
    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            if (hit.lp_lo)       bus_rdata = lp_rd_lo;
            else if (hit.lp_hi)  bus_rdata = lp_rd_hi;
            else if (hit.colpar) bus_rdata = DATA_W'(ecc_cp);
            else if (hit.count)  bus_rdata = ecc_cnt[DATA_W-1:0];
            else if (hit.data)   bus_rdata = nand_din;
            else if (hit.ctrl)   bus_rdata = ctl_q | (DATA_W'(nand_rdy) << CB_BUSY);
        end
    end
endmodule

// File: rtl/nandc_chk.sv
// Property checker for nand_ecc_ctrl, attached with bind below.
// Assumes the host inputs are known while bus_sel is high.
module nandc_chk #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               nand_ce,
    input logic               nand_wr_stb,
    input logic               nand_rd_stb,
    input logic [DATA_W-1:0]  nand_dout,
    input logic [DATA_W-1:0]  nand_din,
    input logic               nand_rdy,
    input logic [DATA_W-1:0]  ctl_q,
    input logic [COUNT_W-1:0] ecc_cnt,
    input logic [2*$clog2(DATA_W)-1:0] ecc_cp,
    input logic [DATA_W-1:0]  ecc_lp0,
    input logic [DATA_W-1:0]  ecc_lp1
);
    logic io_w, io_r, io_any, clr_w, ctl_w, ctl_r, mapped_rd;
    logic [DATA_W-1:0] acc_b;

    // Independent view of the host access
    assign io_w   = bus_sel &&  bus_wr && bus_addr == ADDR_W'(8'h14);
    assign io_r   = bus_sel && !bus_wr && bus_addr == ADDR_W'(8'h14);
    assign io_any = io_w || io_r;
    assign clr_w  = bus_sel &&  bus_wr && bus_addr == ADDR_W'(8'h10);
    assign ctl_w  = bus_sel &&  bus_wr && bus_addr == ADDR_W'(8'h18);
    assign ctl_r  = bus_sel && !bus_wr && bus_addr == ADDR_W'(8'h18);
    assign mapped_rd = bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h04) ||
                       bus_addr == ADDR_W'(8'h08) || bus_addr == ADDR_W'(8'h0C) ||
                       bus_addr == ADDR_W'(8'h14) || bus_addr == ADDR_W'(8'h18);
    assign acc_b  = io_w ? bus_wdata : nand_din;

    AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_w |=> ctl_q == ($past(bus_wdata) & ~DATA_W'(8'h20))); // R2
    AST_CTL_RDY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_r |-> bus_rdata[5] == nand_rdy); // R2
    AST_CE_EITHER: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_w |=> nand_ce == ($past(bus_wdata[0]) || $past(bus_wdata[4]))); // R3
    AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        io_w |-> nand_wr_stb && nand_dout == bus_wdata); // R4
    AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !io_w |-> !nand_wr_stb); // R4
    AST_RD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        io_r |-> nand_rd_stb && bus_rdata == nand_din); // R5
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !io_r |-> !nand_rd_stb); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        io_any |=> ecc_cnt == $past(ecc_cnt) + COUNT_W'(1)); // R6
    AST_CP_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_any && acc_b == '0) |=> $stable(ecc_cp)); // R7
    AST_LP_EVEN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_any && !(^acc_b)) |=> $stable(ecc_lp0) && $stable(ecc_lp1)); // R8
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> ecc_cnt == '0 && ecc_cp == '0 && ecc_lp0 == '0 && ecc_lp1 == '0); // R10
    AST_ECC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_any && !clr_w) |=> $stable(ecc_cnt) && $stable(ecc_cp) &&
                                $stable(ecc_lp0) && $stable(ecc_lp1)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !mapped_rd) |-> bus_rdata == '0); // R11
endmodule

bind nand_ecc_ctrl nandc_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nand_ce(nand_ce), .nand_wr_stb(nand_wr_stb), .nand_rd_stb(nand_rd_stb),
    .nand_dout(nand_dout), .nand_din(nand_din), .nand_rdy(nand_rdy),
    .ctl_q(ctl_q), .ecc_cnt(ecc_cnt), .ecc_cp(ecc_cp),
    .ecc_lp0(ecc_lp0), .ecc_lp1(ecc_lp1)
);

// File: tb/sim_nand_ecc_ctrl.sv
// Self-checking bench for nand_ecc_ctrl with a simple NAND responder.
module sim_nand_ecc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int COUNT_W = 16;

    // {wdata, rdy, expected readback, expected pins {ce,cle,ale,wp}}
    localparam logic [31:0] CTL_VEC [7] = '{
        32'h01000108, 32'h10013008, 32'h22000204, 32'h24012402,
        32'hC800C801, 32'hFF01FF0F, 32'h00012000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
    logic nand_cle, nand_ale, nand_ce, nand_wp, nand_wr_stb, nand_rd_stb;
    logic [DATA_W-1:0] nand_dout, nand_din;
    logic nand_rdy = 1'b0;

    int n_chk = 0, n_err = 0;
    logic done = 1'b0;
    logic wr_seen, rd_seen;
    logic [7:0] dout_seen;

    // NAND responder: a preloaded page read out in order
    logic [7:0] page_mem [256];
    logic [7:0] rd_ptr;
    always @(posedge clk) begin
        if (!rst_n) rd_ptr <= 8'd0;
        else if (nand_rd_stb) rd_ptr <= rd_ptr + 8'd1;
    end
    assign nand_din = page_mem[rd_ptr];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce(nand_ce),
        .nand_wp(nand_wp), .nand_dout(nand_dout), .nand_wr_stb(nand_wr_stb),
        .nand_din(nand_din), .nand_rd_stb(nand_rd_stb), .nand_rdy(nand_rdy)
    );

    // Reference ECC state built from the requirement text
    logic [7:0] ref_cp, ref_a, ref_b, ref_cnt;

    task automatic ref_clear();
        ref_cp = 8'h00; ref_a = 8'h00; ref_b = 8'h00; ref_cnt = 8'h00;
    endtask

    task automatic ref_add(input logic [7:0] b);
        ref_cp[0] = ref_cp[0] ^ (^(b & 8'h55));
        ref_cp[1] = ref_cp[1] ^ (^(b & 8'hAA));
        ref_cp[2] = ref_cp[2] ^ (^(b & 8'h33));
        ref_cp[3] = ref_cp[3] ^ (^(b & 8'hCC));
        ref_cp[4] = ref_cp[4] ^ (^(b & 8'h0F));
        ref_cp[5] = ref_cp[5] ^ (^(b & 8'hF0));
        if (^b) begin
            ref_a = ref_a ^ ~ref_cnt;
            ref_b = ref_b ^ ref_cnt;
        end
        ref_cnt = ref_cnt + 8'd1;
    endtask

    function automatic logic [7:0] exp_lo(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            r[2*k] = a[4+k]; r[2*k+1] = b[4+k];
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_hi(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            r[2*k] = a[k]; r[2*k+1] = b[k];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        wr_seen = nand_wr_stb;
        dout_seen = nand_dout;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        rd_seen = nand_rd_stb;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_ecc(input string tag);
        logic [7:0] r;
        bus_read(6'h0C, r); check({tag, " R6 count"}, r, ref_cnt);
        bus_read(6'h08, r); check({tag, " R7 colpar"}, r, ref_cp);
        bus_read(6'h00, r); check({tag, " R9 R8 line lo"}, r, exp_lo(ref_a, ref_b));
        bus_read(6'h04, r); check({tag, " R9 R8 line hi"}, r, exp_hi(ref_a, ref_b));
    endtask

    initial begin
        logic [7:0] r;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) page_mem[i] = 8'($urandom);
        ref_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 pins", {nand_ce, nand_cle, nand_ale, nand_wp}, 4'b0000);
        bus_read(6'h18, r); check("R1 ctrl", r, 8'h00);
        check_ecc("R1");

        // R2 R3: control vector table
        for (int v = 0; v < 7; v++) begin
            logic [31:0] e;
            e = CTL_VEC[v];
            bus_write(6'h18, e[31:24]);
            nand_rdy = e[16];
            bus_read(6'h18, r);
            check("R2 ctrl readback", r, e[15:8]);
            check("R3 pins", {nand_ce, nand_cle, nand_ale, nand_wp}, e[3:0]);
        end

        // R4 R6 R7 R8 R9: write a full random page
        for (int i = 0; i < 256; i++) begin
            b = 8'($urandom);
            bus_write(6'h14, b);
            if (i < 4) begin
                check("R4 write strobe", wr_seen, 1'b1);
                check("R4 write data", dout_seen, b);
            end
            ref_add(b);
        end
        check_ecc("write page");

        // R10: clear with nonzero data, control kept
        nand_rdy = 1'b0;
        bus_write(6'h18, 8'h13);
        bus_write(6'h10, 8'hA5);
        ref_clear();
        check_ecc("R10 clear");
        bus_read(6'h18, r); check("R10 ctrl kept", r, 8'h13);

        // R5 R6 R7 R8 R9: read a full page from the responder
        for (int i = 0; i < 256; i++) begin
            bus_read(6'h14, r);
            if (i < 4) begin
                check("R5 read strobe", rd_seen, 1'b1);
                check("R5 read data", r, page_mem[i]);
            end
            ref_add(page_mem[i]);
        end
        check_ecc("read page");

        // R6 R8: short run after a clear with zero data
        bus_write(6'h10, 8'h00);
        ref_clear();
        bus_write(6'h14, 8'h01); ref_add(8'h01);
        bus_write(6'h14, 8'h03); ref_add(8'h03);
        bus_write(6'h14, 8'h80); ref_add(8'h80);
        check_ecc("short run");
        bus_read(6'h0C, r); check("R6 count three", r, 8'h03);
        bus_read(6'h00, r); check("R9 line lo short", r, 8'h00);
        bus_read(6'h04, r); check("R9 line hi short", r, 8'h0C);

        // R11: unmapped reads and ignored writes
        bus_read(6'h3C, r); check("R11 read 0x3C", r, 8'h00);
        bus_read(6'h11, r); check("R11 read 0x11", r, 8'h00);
        bus_read(6'h10, r); check("R11 read clear reg", r, 8'h00);
        bus_write(6'h1C, 8'hFF);
        check("R11 no strobe", wr_seen, 1'b0);
        bus_write(6'h0C, 8'h55);
        bus_write(6'h00, 8'hAA);
        bus_write(6'h3F, 8'h00);
        bus_read(6'h18, r); check("R11 ctrl unchanged", r, 8'h13);
        check_ecc("R11 ecc unchanged");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule